// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers sixteen maskable interrupt sources for a CPU core: fourteen active-low external request lines and two requests from the emulation logic (one for data logging, one for a real-time monitor). Every detected request is latched into a pending-flag register. The flag is kept whether or not the source is enabled. Each pending flag is qualified by a per-source enable register and a single global mask bit. The block then hands one approved interrupt at a time to the CPU's interrupt sequencer.

When an interrupt is approved, the block emits a one-cycle take pulse carrying a 4-bit source index. In the same step it clears that source's flag and enable bit, and it captures a return address equal to the current PC plus the size of the current instruction. Further approvals are locked out until the sequencer reports that the service routine has begun. At that point the global mask bit is raised. Software can set and clear flags through strobed write ports, and can read and write the enable register and the global mask.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Each external line passes through a two-flop synchronizer. A high-to-low transition on line k (k = 0..13) sets flag bit k at the third rising edge after the change, counting the edge that first samples it. A line held low sets the flag only once per falling edge.
- R2: A high level on the data-log emulation request sets flag bit 14 at the next edge. A high level on the real-time-monitor emulation request sets flag bit 15 at the next edge.
- R3: A flag stays set while its enable bit is 0 or the global mask is 1. It clears only by approval or by a software clear.
- R4: A flag-set write ORs the write data into the flags, and a flag-clear write clears the bits written as 1. A set from any source in the same cycle wins over a clear, whether the clear comes from software or from approval.
- R5: An approval happens only when some flag has its enable bit at 1, the global mask is 0 and no lockout is active. The take output is high for exactly the one cycle after the approval edge.
- R6: Among approvable sources, the one with the lowest bit number wins. The take index gives that bit number in binary.
- R7: Approval clears the chosen source's flag bit and its enable bit, and a software enable write in the same cycle does not restore that bit.
- R8: After an approval, no further approval occurs until the ISR-started input is high while the lockout is active. That event releases the lockout and sets the global mask to 1.
- R9: The return-address output captures the PC input plus 2 when the long-instruction input is 1, and plus 1 otherwise, at the approval edge. It holds that value until the next approval.
- R10: Reset clears all flags, all enables, the lockout and the take output, and sets the global mask to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 14 | External interrupt request lines, active low |
| emu_log_req | input | 1 | Emulation data-log request, sets flag 14 |
| emu_rtos_req | input | 1 | Emulation real-time-monitor request, sets flag 15 |
| sw_flag_set_we | input | 1 | Strobe: OR sw_flag_wdata into the flags |
| sw_flag_clr_we | input | 1 | Strobe: clear the flags written as 1 |
| sw_flag_wdata | input | 16 | Data for flag set and clear writes |
| sw_en_we | input | 1 | Strobe: load the enable register |
| sw_en_wdata | input | 16 | Enable register write data |
| sw_mask_we | input | 1 | Strobe: load the global mask bit |
| sw_mask_wdata | input | 1 | Global mask write data (1 = masked) |
| pc_i | input | 22 | Current program counter |
| instr_long_i | input | 1 | Current instruction is two words long |
| isr_start_i | input | 1 | Sequencer reports that the service routine has begun |
| flag_o | output | 16 | Pending-flag register |
| en_o | output | 16 | Enable register |
| gmask_o | output | 1 | Global mask bit |
| take_o | output | 1 | One-cycle interrupt-take pulse |
| take_idx_o | output | 4 | Index of the taken source |
| ret_addr_o | output | 22 | Captured return address |

## Verification
Assertions check on every cycle that the take pulse lasts one cycle, that it never appears while the lockout holds or after a masked cycle, and that the taken source's enable bit has been cleared. They also check that a software-set flag is visible after the write, that the ISR-started event raises the mask and drops the lockout, and that the chosen index is the lowest approvable one. Only the bench's scenarios show the synchronizer latency and the single set per falling edge, the fact that a line held low after approval does not re-flag, and re-flagging on a fresh edge during lockout. The scenarios also cover the emulation request bit positions, the set-over-clear ordering and the return-address arithmetic.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DEF_N_EXT = 14;
    localparam int DEF_N_EMU = 2;
    localparam int DEF_PC_W  = 22;

    // Return address step for the current instruction size
    function automatic logic [1:0] instr_step(input logic is_long);
        return is_long ? 2'd2 : 2'd1;
    endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_n,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] s1_q, s2_q, s3_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q[i] <= 1'b1;
                s2_q[i] <= 1'b1;
                s3_q[i] <= 1'b1;
            end else begin
                s1_q[i] <= line_n[i];
                s2_q[i] <= s1_q[i];
                s3_q[i] <= s2_q[i];
            end
        end
        assign fall_o[i] = s3_q[i] & ~s2_q[i];
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        vld_o = |req;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int N_EXT = irq_pkg::DEF_N_EXT,
    parameter int N_EMU = irq_pkg::DEF_N_EMU,
    parameter int PC_W  = irq_pkg::DEF_PC_W,
    localparam int N_SRC = N_EXT + N_EMU,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_irq_n,
    input  logic             emu_log_req,
    input  logic             emu_rtos_req,
    input  logic             sw_flag_set_we,
    input  logic             sw_flag_clr_we,
    input  logic [N_SRC-1:0] sw_flag_wdata,
    input  logic             sw_en_we,
    input  logic [N_SRC-1:0] sw_en_wdata,
    input  logic             sw_mask_we,
    input  logic             sw_mask_wdata,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             instr_long_i,
    input  logic             isr_start_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] en_o,
    output logic             gmask_o,
    output logic             take_o,
    output logic [IDX_W-1:0] take_idx_o,
    output logic [PC_W-1:0]  ret_addr_o
);
    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
        logic             gmask;
        logic             lock;
        logic             take;
        logic [IDX_W-1:0] idx;
        logic [PC_W-1:0]  ret;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;

    logic [N_EXT-1:0] ext_fall;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] hw_set, sw_set, clr_mask;
    logic             pick_vld, approve;
    logic [IDX_W-1:0] pick_idx;

    irq_edge_sync #(.WIDTH(N_EXT)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (ext_irq_n),
        .fall_o (ext_fall)
    );

    assign pend = st_q.flag & st_q.en;

    irq_prio_pick #(.N(N_SRC)) u_pick (
        .req   (pend),
        .vld_o (pick_vld),
        .idx_o (pick_idx)
    );

    assign approve = pick_vld & ~st_q.lock & ~st_q.gmask;

    always_comb begin
        st_d     = st_q;
        st_d.take = 1'b0;
        hw_set   = {{(N_EMU-2){1'b0}}, emu_rtos_req, emu_log_req, ext_fall};
        sw_set   = sw_flag_set_we ? sw_flag_wdata : '0;
        clr_mask = sw_flag_clr_we ? sw_flag_wdata : '0;
        if (sw_en_we)   st_d.en    = sw_en_wdata;
        if (sw_mask_we) st_d.gmask = sw_mask_wdata;
        if (approve) begin
            clr_mask          = clr_mask | (N_SRC'(1) << pick_idx);
            st_d.en[pick_idx] = 1'b0;
            st_d.lock         = 1'b1;
            st_d.take         = 1'b1;
            st_d.idx          = pick_idx;
            st_d.ret          = pc_i + PC_W'(irq_pkg::instr_step(instr_long_i));
        end
        if (isr_start_i && st_q.lock) begin
            st_d.lock  = 1'b0;
            st_d.gmask = 1'b1;
        end
        st_d.flag = (st_q.flag & ~clr_mask) | hw_set | sw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.gmask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o     = st_q.flag;
    assign en_o       = st_q.en;
    assign gmask_o    = st_q.gmask;
    assign take_o     = st_q.take;
    assign take_idx_o = st_q.idx;
    assign ret_addr_o = st_q.ret;

    // R5
    take_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R5
    take_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !$past(gmask_o));

    // R8
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !isr_start_i) |=> !take_o);

    // R8
    isr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && isr_start_i) |=> (gmask_o && !st_q.lock));

    // R7
    take_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !en_o[take_idx_o]);

    // R4
    sw_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_flag_set_we |=> ((flag_o & $past(sw_flag_wdata)) == $past(sw_flag_wdata)));

    // R6
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> (pend[pick_idx] && ((pend & ((N_SRC'(1) << pick_idx) - N_SRC'(1))) == '0)));
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ext_irq_n = '1;
    logic        emu_log_req = 0, emu_rtos_req = 0;
    logic        sw_flag_set_we = 0, sw_flag_clr_we = 0;
    logic [15:0] sw_flag_wdata = '0;
    logic        sw_en_we = 0;
    logic [15:0] sw_en_wdata = '0;
    logic        sw_mask_we = 0, sw_mask_wdata = 0;
    logic [21:0] pc_i = '0;
    logic        instr_long_i = 0;
    logic        isr_start_i = 0;
    logic [15:0] flag_o, en_o;
    logic        gmask_o, take_o;
    logic [3:0]  take_idx_o;
    logic [21:0] ret_addr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n),
        .emu_log_req(emu_log_req), .emu_rtos_req(emu_rtos_req),
        .sw_flag_set_we(sw_flag_set_we), .sw_flag_clr_we(sw_flag_clr_we),
        .sw_flag_wdata(sw_flag_wdata), .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
        .sw_mask_we(sw_mask_we), .sw_mask_wdata(sw_mask_wdata),
        .pc_i(pc_i), .instr_long_i(instr_long_i), .isr_start_i(isr_start_i),
        .flag_o(flag_o), .en_o(en_o), .gmask_o(gmask_o), .take_o(take_o),
        .take_idx_o(take_idx_o), .ret_addr_o(ret_addr_o)
    );

    // Vector table: flags written, enables written, take expected, index expected
    localparam logic [15:0] VF [8] = '{16'h0001, 16'h8000, 16'h00A0, 16'h00A0,
                                       16'hFFFF, 16'hC000, 16'h1000, 16'h0300};
    localparam logic [15:0] VE [8] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0080,
                                       16'h0000, 16'hC000, 16'h1000, 16'h0200};
    localparam logic        VT [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [3:0]  VI [8] = '{4'd0, 4'd15, 4'd5, 4'd7, 4'd0, 4'd14, 4'd12, 4'd9};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_irq_n = '1; emu_log_req = 0; emu_rtos_req = 0;
        sw_flag_set_we = 0; sw_flag_clr_we = 0; sw_en_we = 0; sw_mask_we = 0;
        isr_start_i = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic clear_strobes();
        sw_flag_set_we = 0; sw_flag_clr_we = 0; sw_en_we = 0; sw_mask_we = 0;
        isr_start_i = 0; emu_log_req = 0; emu_rtos_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] bit_v;
        do_reset();
        // R10 reset state
        chk(flag_o == 16'h0, "R10 flags", 32'(flag_o), 0);
        chk(en_o == 16'h0, "R10 enables", 32'(en_o), 0);
        chk(gmask_o == 1'b1, "R10 mask", 32'(gmask_o), 1);
        chk(take_o == 1'b0, "R10 take", 32'(take_o), 0);

        // Table walk: R5 R6 R7 R3
        for (int i = 0; i < 8; i++) begin
            do_reset();
            sw_en_we = 1; sw_en_wdata = VE[i];
            sw_flag_set_we = 1; sw_flag_wdata = VF[i];
            sw_mask_we = 1; sw_mask_wdata = 0;
            cyc(1);
            clear_strobes();
            cyc(1);
            bit_v = VT[i] ? (16'h1 << VI[i]) : 16'h0;
            chk(take_o == VT[i], "R5 take", 32'(take_o), 32'(VT[i]));
            if (VT[i]) chk(take_idx_o == VI[i], "R6 index", 32'(take_idx_o), 32'(VI[i]));
            chk(flag_o == (VF[i] & ~bit_v), "R7 R3 flags after", 32'(flag_o), 32'(VF[i] & ~bit_v));
            chk(en_o == (VE[i] & ~bit_v), "R7 enables after", 32'(en_o), 32'(VE[i] & ~bit_v));
        end

        // R1 synchronizer latency and single set per falling edge
        do_reset();
        ext_irq_n[3] = 1'b0;
        cyc(2);
        chk(flag_o[3] == 1'b0, "R1 not yet", 32'(flag_o[3]), 0);
        cyc(1);
        chk(flag_o[3] == 1'b1, "R1 flag set", 32'(flag_o[3]), 1);
        cyc(5);
        sw_en_we = 1; sw_en_wdata = 16'h0008;
        sw_mask_we = 1; sw_mask_wdata = 0;
        pc_i = 22'h100; instr_long_i = 1;
        cyc(1);
        clear_strobes();
        cyc(1);
        chk(take_o && take_idx_o == 4'd3, "R5 R1 take line", 32'(take_idx_o), 3);
        chk(ret_addr_o == 22'h102, "R9 long", 32'(ret_addr_o), 32'h102);
        cyc(4);
        chk(flag_o[3] == 1'b0, "R1 held low no refire", 32'(flag_o[3]), 0);

        // R8 lockout
        sw_en_we = 1; sw_en_wdata = 16'h0002;
        sw_flag_set_we = 1; sw_flag_wdata = 16'h0002;
        sw_mask_we = 1; sw_mask_wdata = 0;
        cyc(1);
        clear_strobes();
        cyc(4);
        chk(take_o == 1'b0 && flag_o[1], "R8 locked", 32'(take_o), 0);
        ext_irq_n[3] = 1'b1;
        cyc(3);
        ext_irq_n[3] = 1'b0;
        cyc(3);
        chk(flag_o[3] == 1'b1, "R1 new edge refire", 32'(flag_o[3]), 1);
        isr_start_i = 1;
        cyc(1);
        isr_start_i = 0;
        chk(gmask_o == 1'b1, "R8 mask raised", 32'(gmask_o), 1);
        cyc(3);
        chk(take_o == 1'b0, "R8 masked after isr", 32'(take_o), 0);
        pc_i = 22'h2000; instr_long_i = 0;
        sw_mask_we = 1; sw_mask_wdata = 0;
        cyc(1);
        clear_strobes();
        cyc(1);
        chk(take_o && take_idx_o == 4'd1, "R6 R8 take after release", 32'(take_idx_o), 1);
        chk(ret_addr_o == 22'h2001, "R9 short", 32'(ret_addr_o), 32'h2001);
        chk(flag_o[3] == 1'b1, "R3 disabled flag kept", 32'(flag_o[3]), 1);

        // R2 emulation requests
        do_reset();
        emu_log_req = 1;
        cyc(1);
        emu_log_req = 0;
        chk(flag_o == 16'h4000, "R2 data-log bit14", 32'(flag_o), 32'h4000);
        emu_rtos_req = 1;
        cyc(1);
        emu_rtos_req = 0;
        chk(flag_o == 16'hC000, "R2 rtos bit15", 32'(flag_o), 32'hC000);

        // R4 clear and set-over-clear
        sw_flag_clr_we = 1; sw_flag_wdata = 16'h4000;
        cyc(1);
        clear_strobes();
        chk(flag_o == 16'h8000, "R4 clear", 32'(flag_o), 32'h8000);
        sw_flag_clr_we = 1; sw_flag_wdata = 16'h8000;
        emu_log_req = 1;
        cyc(1);
        clear_strobes();
        chk(flag_o == 16'h4000, "R4 hw set beats clear", 32'(flag_o), 32'h4000);
        sw_flag_set_we = 1; sw_flag_clr_we = 1; sw_flag_wdata = 16'h0010;
        cyc(1);
        clear_strobes();
        chk(flag_o == 16'h4010, "R4 set beats clear", 32'(flag_o), 32'h4010);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule